// File: doc/BRIEF.md
# Five-Bit Symbol Serializer with Three-Level Line Encoder

This block sits at the transmit end of a twisted-pair physical layer. It runs on a single bit-rate clock, which is five times the symbol rate. A divide-by-five phase counter marks one cycle in five as the symbol capture cycle and shows it on `sym_tick`. The 5-bit code group on `tx_sym` is taken at the end of that cycle. On the next phase it is handed to a shift register, which sends bit 4 first and bit 0 last, with no gap between symbols.

Each serial bit goes through an NRZ-to-NRZI stage. A four-state line encoder then steps through zero, positive, zero, negative, and moves one step for every transition of the NRZI stream. The line level is given as two enables. Positive drives the high side only. Negative drives the low side only. Zero drives both.

An active-low disable forces both enables low at once, for a quiet line. An active-low pass-through select, sampled together with the symbol, turns that symbol period into a link-pulse slot. In such a slot bit 4 alone decides whether the line sits at the positive level or at zero, and the encoder state is left as it was.

Top module: `sym_mlt3_tx`

The line encoder FSM has four states: `LV_ZERO_UP` (the zero level before a positive pulse), `LV_POS`, `LV_ZERO_DN` (the zero level before a negative pulse) and `LV_NEG`. It has two transitions. A step moves to the next state in the ring `LV_ZERO_UP` to `LV_POS` to `LV_ZERO_DN` to `LV_NEG` and back to `LV_ZERO_UP`, and is taken when the NRZI input differs from its last seen value. A hold keeps the current state otherwise.

## Requirements
- R1: While `rst_n` is low, and directly after it goes low, both `line_hi_en` and `line_lo_en` are 1, which is the zero level, and `sym_tick` is 0. Reset puts the encoder in `LV_ZERO_UP` and clears the NRZI state.
- R2: After reset, `sym_tick` is 1 for exactly one cycle in every five. The value on `tx_sym` and `an_n` in that cycle is the one captured.
- R3: Call the cycle in which a symbol is captured cycle 0. Its bit 4 sets the line level seen in cycle 4. Bits 3, 2, 1 and 0 follow in cycles 5 to 8. Back-to-back symbols form a continuous stream with no bit dropped or repeated.
- R4: In normal mode a 1 bit moves the level one step around the ring zero, +1, zero, -1. A 0 bit keeps the level. The encoding is NRZI followed by a step on each NRZI transition.
- R5: When `dis_n` is 1, the enables encode the level as follows. Positive is hi=1, lo=0. Negative is hi=0, lo=1. Zero is hi=1, lo=1.
- R6: When `dis_n` is 0, both enables are 0 in that same cycle, whatever the data. The encoder keeps running underneath, so after `dis_n` returns to 1 the line shows the level the stream has reached.
- R7: A symbol captured with `an_n` = 0 is a pass-through slot. For the same five cycles that a normal symbol would occupy, the line is positive if bit 4 was 1 and zero if bit 4 was 0. Bits 3 to 0 are ignored.
- R8: A pass-through slot does not change the encoder state. The next normal symbol continues from the level held before the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, five times the symbol rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_sym | input | 5 | Code group to send, bit 4 first |
| an_n | input | 1 | Active-low link-pulse pass-through select, sampled with the symbol |
| dis_n | input | 1 | Active-low transmit disable, forces a quiet line |
| sym_tick | output | 1 | High in the symbol capture cycle |
| line_hi_en | output | 1 | High-side line enable |
| line_lo_en | output | 1 | Low-side line enable |

## Verification
The level for bit 4 of a symbol taken in a tick cycle is due four cycles later. Each later bit follows one cycle after the one before it, and pass-through slots fill those same five cycles. The disable and reset effects are due in the same cycle.

The bench aligns itself to the first falling edge with `sym_tick` high. It drives a new symbol every fifth falling edge and checks serial position q at falling edge 4+q, one nanosecond after the edge, against a ring-level model that it updates only at that moment. Disable and reset are checked one nanosecond after the input changes, with no clock edge in between.

// File: rtl/sym_tx_pkg.sv
package sym_tx_pkg;

    typedef enum logic [1:0] {
        LV_ZERO_UP = 2'd0,
        LV_POS     = 2'd1,
        LV_ZERO_DN = 2'd2,
        LV_NEG     = 2'd3
    } mlt_state_t;

    function automatic mlt_state_t mlt_step(mlt_state_t s);
        mlt_state_t n;
        unique case (s)
            LV_ZERO_UP: n = LV_POS;
            LV_POS:     n = LV_ZERO_DN;
            LV_ZERO_DN: n = LV_NEG;
            LV_NEG:     n = LV_ZERO_UP;
            default:    n = LV_ZERO_UP;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/tx_sym_serializer.sv
module tx_sym_serializer #(
    parameter int SYM_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SYM_W-1:0] sym_in,
    input  logic             pass_n,
    output logic             tick,
    output logic             ser_bit,
    output logic             pt_mode,
    output logic             pt_level
);
    localparam int PH_W = $clog2(SYM_W);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(SYM_W - 1);

    logic [PH_W-1:0]  ph_q;
    logic [SYM_W-1:0] sym_q;
    logic             mode_q;
    logic [SYM_W-1:0] sh_q;
    logic             load;

    assign tick = (ph_q == LAST_PH);
    assign load = (ph_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q     <= '0;
            sym_q    <= '0;
            mode_q   <= 1'b0;
            sh_q     <= '0;
            pt_mode  <= 1'b0;
            pt_level <= 1'b0;
        end else begin
            ph_q <= tick ? '0 : ph_q + 1'b1;
            if (tick) begin
                sym_q  <= sym_in;
                mode_q <= ~pass_n;
            end
            if (load) begin
                sh_q     <= mode_q ? '0 : sym_q;
                pt_mode  <= mode_q;
                pt_level <= mode_q & sym_q[SYM_W-1];
            end else begin
                sh_q <= {sh_q[SYM_W-2:0], 1'b0};
            end
        end
    end

    assign ser_bit = sh_q[SYM_W-1];

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R2

    AST_PT_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (load && mode_q) |=> (sh_q == '0)); // R7

endmodule

// File: rtl/tx_nrzi.sv
module tx_nrzi (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    output logic nrzi_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) nrzi_q <= 1'b0;
        else        nrzi_q <= nrzi_q ^ bit_in;
    end

    AST_NRZI_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        bit_in |=> (nrzi_q != $past(nrzi_q))); // R4

    AST_NRZI_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_in |=> $stable(nrzi_q)); // R4

endmodule

// File: rtl/tx_mlt3_fsm.sv
module tx_mlt3_fsm
    import sym_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic nrzi_in,
    output logic lvl_hi,
    output logic lvl_lo
);
    mlt_state_t state_q, state_d;
    logic       last_q;

    always_comb begin
        if (nrzi_in != last_q) state_d = mlt_step(state_q);
        else                   state_d = state_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LV_ZERO_UP;
            last_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            last_q  <= nrzi_in;
        end
    end

    always_comb begin
        unique case (state_q)
            LV_POS:  begin lvl_hi = 1'b1; lvl_lo = 1'b0; end
            LV_NEG:  begin lvl_hi = 1'b0; lvl_lo = 1'b1; end
            default: begin lvl_hi = 1'b1; lvl_lo = 1'b1; end
        endcase
    end

    AST_RING_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != $past(state_q)) |-> (state_q == mlt_step($past(state_q)))); // R4

    AST_RING_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (nrzi_in == last_q) |=> (state_q == $past(state_q))); // R4

endmodule

// File: rtl/sym_mlt3_tx.sv
module sym_mlt3_tx #(
    parameter int SYM_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SYM_W-1:0] tx_sym,
    input  logic             an_n,
    input  logic             dis_n,
    output logic             sym_tick,
    output logic             line_hi_en,
    output logic             line_lo_en
);
    localparam int PT_DLY = 2;

    logic ser_bit, pt_mode, pt_level, nrzi, enc_hi, enc_lo;
    logic [PT_DLY-1:0][1:0] pt_dq;

    tx_sym_serializer #(.SYM_W(SYM_W)) u_ser (
        .clk(clk), .rst_n(rst_n), .sym_in(tx_sym), .pass_n(an_n),
        .tick(sym_tick), .ser_bit(ser_bit),
        .pt_mode(pt_mode), .pt_level(pt_level)
    );

    tx_nrzi u_nrzi (
        .clk(clk), .rst_n(rst_n), .bit_in(ser_bit), .nrzi_q(nrzi)
    );

    tx_mlt3_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .nrzi_in(nrzi),
        .lvl_hi(enc_hi), .lvl_lo(enc_lo)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pt_dq <= '0;
        end else begin
            pt_dq[0] <= {pt_mode, pt_level};
            for (int i = 1; i < PT_DLY; i++) pt_dq[i] <= pt_dq[i-1];
        end
    end

    always_comb begin
        if (!dis_n) begin
            line_hi_en = 1'b0;
            line_lo_en = 1'b0;
        end else if (pt_dq[PT_DLY-1][1]) begin
            line_hi_en = 1'b1;
            line_lo_en = ~pt_dq[PT_DLY-1][0];
        end else begin
            line_hi_en = enc_hi;
            line_lo_en = enc_lo;
        end
    end

    AST_LINE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        dis_n |-> (line_hi_en || line_lo_en)); // R5

endmodule

// File: tb/sym_mlt3_tx_test.sv
`timescale 1ns/1ps
module sym_mlt3_tx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] tx_sym = 5'd0;
    logic       an_n = 1'b1;
    logic       dis_n = 1'b1;
    logic       sym_tick, line_hi_en, line_lo_en;

    int checks = 0;
    int errors = 0;
    int lvl = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sym_mlt3_tx uut (
        .clk(clk), .rst_n(rst_n), .tx_sym(tx_sym), .an_n(an_n), .dis_n(dis_n),
        .sym_tick(sym_tick), .line_hi_en(line_hi_en), .line_lo_en(line_lo_en)
    );

    // {disable, pass-through, symbol}
    localparam int NV = 12;
    localparam logic [6:0] VEC [NV] = '{
        {2'b00, 5'b11111}, {2'b00, 5'b00000}, {2'b00, 5'b10101},
        {2'b00, 5'b01000}, {2'b10, 5'b11011}, {2'b00, 5'b00111},
        {2'b01, 5'b10000}, {2'b01, 5'b01111}, {2'b00, 5'b10001},
        {2'b01, 5'b11111}, {2'b00, 5'b11001}, {2'b00, 5'b00001}
    };

    function automatic logic [1:0] lvl_pins(int l);
        if (l == 1) return 2'b10;
        if (l == 3) return 2'b01;
        return 2'b11;
    endfunction

    task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        #100000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        #1 chk("R1 reset enables", {line_hi_en, line_lo_en}, 2'b11);
        chk("R1 reset tick", {1'b0, sym_tick}, 2'b00);
        @(negedge clk) rst_n = 1'b1;
        lvl = 0;

        // align on the first capture cycle
        do @(negedge clk); while (sym_tick !== 1'b1);

        // R3 R4 R5 R6 R7 R8 stream walk
        for (int t = 0; t < 5 * NV + 4; t++) begin
            if (t > 0) @(negedge clk);
            if (t % 5 == 0) begin
                chk("R2 tick phase", {1'b0, sym_tick}, 2'b01);
                if (t / 5 < NV) begin
                    tx_sym = VEC[t/5][4:0];
                    an_n   = ~VEC[t/5][5];
                end else begin
                    tx_sym = 5'd0;
                    an_n   = 1'b1;
                end
            end else if (t % 5 == 1) begin
                chk("R2 tick low", {1'b0, sym_tick}, 2'b00);
            end
            if (t >= 4) begin
                int q;
                int k;
                int s;
                logic [1:0] exp;
                q = t - 4;
                k = q / 5;
                s = q % 5;
                dis_n = ~VEC[k][6];
                if (VEC[k][5]) begin
                    exp = VEC[k][4] ? 2'b10 : 2'b11;
                end else begin
                    if (VEC[k][4-s]) lvl = (lvl + 1) % 4;
                    exp = lvl_pins(lvl);
                end
                if (VEC[k][6]) exp = 2'b00;
                #1;
                if (VEC[k][6])      chk("R6 quiet line", {line_hi_en, line_lo_en}, exp);
                else if (VEC[k][5]) chk("R7 pass-through level", {line_hi_en, line_lo_en}, exp);
                else if (k > 0 && VEC[k-1][5])
                                    chk("R8 level after pass-through", {line_hi_en, line_lo_en}, exp);
                else                chk("R3 R4 R5 serial level", {line_hi_en, line_lo_en}, exp);
            end
        end
        dis_n = 1'b1;

        // R4 zeros hold the level
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            #1 chk("R4 hold on zeros", {line_hi_en, line_lo_en}, lvl_pins(lvl));
        end

        // R6 immediate disable with no clock edge
        @(negedge clk);
        dis_n = 1'b0;
        #1 chk("R6 same-cycle quiet", {line_hi_en, line_lo_en}, 2'b00);
        dis_n = 1'b1;
        #1 chk("R6 restore level", {line_hi_en, line_lo_en}, lvl_pins(lvl));

        // R1 asynchronous reset while a pulse is driven
        tx_sym = 5'b10000;
        do @(negedge clk); while (sym_tick !== 1'b1);
        repeat (4) @(negedge clk);
        lvl = (lvl + 1) % 4;
        #1 chk("R4 single step", {line_hi_en, line_lo_en}, lvl_pins(lvl));
        rst_n = 1'b0;
        #1 chk("R1 async reset level", {line_hi_en, line_lo_en}, 2'b11);
        chk("R1 async reset tick", {1'b0, sym_tick}, 2'b00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule